// File: doc/BRIEF.md
# Multifunction Pipeline Stage Sequencer

This block steers a three-stage nonlinear pipeline whose stages (A, B and C) are joined by input multiplexers that take either the external operand or the output of another stage. Each function the pipeline computes is a fixed walk through the stages, one stage per clock, and a stage may appear more than once in the walk. The sequencer takes start requests tagged with a one-bit function code. In every cycle it drives one enable per stage and a two-bit source select per stage. When an evaluation finishes it emits a one-cycle completion pulse carrying the function code.

Admission is guarded by a per-stage occupancy map that looks six cycles ahead. A request is accepted only if none of the stage slots it needs is already claimed. Otherwise `start_ready` stays low and the requester holds the request. A mode input picks the admission policy. In static mode all in-flight work must belong to one function, so a request for the other function waits until the pipeline is empty. In dynamic mode evaluations of either function may overlap whenever their stage claims do not collide. The arithmetic inside the stages is outside this block.

Top module: `rtseq_sequencer`

## Requirements
- R1: After a synchronous active-low reset, and also after a reset applied while evaluations are in flight, every stage enable is 0, every select is 0, `done_valid` is 0 and `start_ready` is 1.
- R2: An evaluation of function code 0 accepted at a clock edge enables exactly one stage in each of the next six cycles, in the order A, B, C, B, C, A. Stage A is `stage_en[0]`, B is `stage_en[1]` and C is `stage_en[2]`.
- R3: An evaluation of function code 1 enables stages in the order A, C, B, A, B, C over the six cycles after acceptance.
- R4: The select of stage s sits in `stage_sel[2s+1:2s]`. For an enabled stage it is 0 (external operand) in an evaluation's first step. In later steps it is 1, 2 or 3 when the stage the same evaluation used in the previous step was A, B or C. A stage that is not enabled shows 0.
- R5: `done_valid` pulses for exactly one cycle, one cycle after an evaluation's sixth step, with `done_func` equal to that evaluation's function code.
- R6: `start_ready` is low whenever accepting the requested function would make two evaluations claim the same stage in the same cycle. A held request is accepted on the first cycle this is no longer so.
- R7: A stage that the same evaluation revisits does not block that evaluation. Relative to an in-flight evaluation of the same function started d cycles earlier, code 0 is refused for d = 2 and d = 5 and accepted for d = 1, 3 and 4. Code 1 is refused for d = 2, 3 and 4 and accepted for d = 1 and 5.
- R8: In static mode (`mode_dyn` = 0), a request for a function other than the one in flight is refused until no evaluation is in flight. A request for the same function is subject only to R6.
- R9: In dynamic mode (`mode_dyn` = 1), evaluations of different functions overlap when their claims do not collide. Code 1 started d cycles after code 0 is accepted only for d = 4. Code 0 started after code 1 is refused for d = 1 and accepted for d = 2.
- R10: A change of `mode_dyn` while any evaluation is in flight has no effect until the pipeline is empty. The mode seen at the last empty cycle keeps governing admission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_dyn | input | 1 | 1 = overlapped admission, 0 = drain before changing function |
| start_valid | input | 1 | Start request present; held until accepted |
| start_func | input | 1 | Function code of the request |
| start_ready | output | 1 | Request can be accepted this cycle |
| stage_en | output | 3 | Per-stage enable, bit 0 = A, 1 = B, 2 = C |
| stage_sel | output | 6 | Two-bit input source per stage (0 external, 1 A, 2 B, 3 C) |
| done_valid | output | 1 | One-cycle completion pulse |
| done_func | output | 1 | Function code of the completed evaluation |

## Verification
On every cycle the assertions compare the enables decoded from the in-flight evaluation tags with the look-ahead occupancy map, which is built separately. They also check that an accepted request opens on stage A from the external operand, that a completion follows the correct final stage of its function, that static mode never mixes the two functions, and that the latched mode stays fixed while work is in flight. Only the bench scenarios can show the exact step orders and select codes, the precise set of accepted and refused start spacings for each pair of functions, the moment a held request is finally taken, and the way a mode change is deferred until drain.

// File: rtl/rtseq_pkg.sv
// Shared constants and table functions for the stage sequencer.
// Assumes exactly three stages and six-step functions; the step tables
// are computed by functions instead of being stored.
package rtseq_pkg;
    localparam int NSTG  = 3;
    localparam int DEPTH = 6;
    localparam int SELW  = 2;

    localparam logic [1:0] ST_A = 2'd0;
    localparam logic [1:0] ST_B = 2'd1;
    localparam logic [1:0] ST_C = 2'd2;
    localparam logic [1:0] SRC_EXT = 2'd0;

    // Stage used by function f at step k.
    function automatic logic [1:0] step_stage(input logic f, input int k);
        logic [1:0] r;
        r = ST_A;
        if (!f) begin
            case (k)
                1: r = ST_B;
                2: r = ST_C;
                3: r = ST_B;
                4: r = ST_C;
                default: r = ST_A;
            endcase
        end else begin
            case (k)
                1: r = ST_C;
                2: r = ST_B;
                3: r = ST_A;
                4: r = ST_B;
                5: r = ST_C;
                default: r = ST_A;
            endcase
        end
        return r;
    endfunction

    // Reservation row: bit k set when function f uses stage s at step k.
    function automatic logic [DEPTH-1:0] stage_row(input logic f, input int s);
        logic [DEPTH-1:0] r;
        for (int k = 0; k < DEPTH; k++) begin
            r[k] = (step_stage(f, k) == 2'(s));
        end
        return r;
    endfunction

    // Mux source code for function f at step k: external first, else previous stage + 1.
    function automatic logic [1:0] src_code(input logic f, input int k);
        logic [1:0] r;
        if (k == 0) r = SRC_EXT;
        else        r = step_stage(f, k - 1) + 2'd1;
        return r;
    endfunction
endpackage

// File: rtl/rtseq_occupancy.sv
// Look-ahead occupancy map: one shift register per stage, bit j meaning
// the stage is claimed j cycles from now. Reports whether a requested
// function collides with claims already made, and records it on load.
// Assumes load is only raised when clash is low.
module rtseq_occupancy
    import rtseq_pkg::*;
#(
    parameter int N_STAGES = NSTG,
    parameter int WIN      = DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_func,
    input  logic                load,
    output logic                clash,
    output logic [N_STAGES-1:0] busy_now
);
    logic [N_STAGES-1:0] clash_vec;

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        logic [WIN-1:0] occ_q;
        logic [WIN-1:0] row;
        logic [WIN-1:0] ahead;

        // Row of the requested function and the map as it stands next cycle.
        always_comb begin
            row   = stage_row(req_func, s);
            ahead = occ_q >> 1;
        end

        // Advance the map each clock and merge the new function's row on load.
        always_ff @(posedge clk) begin
            if (!rst_n) occ_q <= '0;
            else        occ_q <= ahead | (load ? row : '0);
        end

        assign clash_vec[s] = |(row & ahead);
        assign busy_now[s]  = occ_q[0];

        // A loaded row must never overlap an existing claim (R6).
        assert_load_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            load |-> ((row & ahead) == '0));
    end

    assign clash = |clash_vec;
endmodule

// File: rtl/rtseq_tag_pipe.sv
// In-flight evaluation tags: slot k holds the evaluation currently at step k.
// Produces the completion pulse one cycle after step WIN-1 and tells whether
// any in-flight evaluation belongs to a function other than the query.
module rtseq_tag_pipe
    import rtseq_pkg::*;
#(
    parameter int WIN = DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           load_func,
    input  logic           query_func,
    output logic [WIN-1:0] live,
    output logic [WIN-1:0] func,
    output logic           empty,
    output logic           other_live,
    output logic           done_valid,
    output logic           done_func
);
    // Shift evaluations one step per clock, inserting a new one at step 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
            func <= '0;
        end else begin
            live <= {live[WIN-2:0], load};
            func <= {func[WIN-2:0], load & load_func};
        end
    end

    // Register the completion pulse from the slot that just finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_func  <= 1'b0;
        end else begin
            done_valid <= live[WIN-1];
            done_func  <= live[WIN-1] & func[WIN-1];
        end
    end

    // Pipeline status seen by the admission logic.
    always_comb begin
        empty      = ~|live;
        other_live = |(live & (func ^ {WIN{query_func}}));
    end
endmodule

// File: rtl/rtseq_route.sv
// Decodes the in-flight tags into per-stage enables and input selects.
// Assumes the admission logic guarantees at most one claim per stage, so
// the selects of all matching slots may simply be ORed.
module rtseq_route
    import rtseq_pkg::*;
#(
    parameter int N_STAGES = NSTG,
    parameter int WIN      = DEPTH
) (
    input  logic [WIN-1:0]           live,
    input  logic [WIN-1:0]           func,
    output logic [N_STAGES-1:0]      stage_en,
    output logic [SELW*N_STAGES-1:0] stage_sel
);
    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        logic           en;
        logic [SELW-1:0] sel;

        // Collect the claim on this stage from whichever slot uses it now.
        always_comb begin
            en  = 1'b0;
            sel = '0;
            for (int k = 0; k < WIN; k++) begin
                if (live[k] && step_stage(func[k], k) == 2'(s)) begin
                    en  = 1'b1;
                    sel = sel | src_code(func[k], k);
                end
            end
        end

        assign stage_en[s]              = en;
        assign stage_sel[SELW*s +: SELW] = sel;
    end
endmodule

// File: rtl/rtseq_sequencer.sv
// Top of the stage sequencer. Combines the occupancy map (admission),
// the tag pipe (in-flight evaluations, completion) and the route decoder
// (enables and selects). Applies the static/dynamic admission policy with
// the mode latched while the pipeline is empty.
module rtseq_sequencer
    import rtseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_dyn,
    input  logic                 start_valid,
    input  logic                 start_func,
    output logic                 start_ready,
    output logic [NSTG-1:0]      stage_en,
    output logic [SELW*NSTG-1:0] stage_sel,
    output logic                 done_valid,
    output logic                 done_func
);
    logic             clash;
    logic [NSTG-1:0]  busy_now;
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] func;
    logic             empty;
    logic             other_live;
    logic             accept;
    logic             mode_q;
    logic             mode_eff;

    // Mode follows the input only while nothing is in flight.
    always_comb mode_eff = empty ? mode_dyn : mode_q;

    // Hold the mode last seen while empty.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_eff;
    end

    // Admission: no stage collision, and in static mode no foreign function in flight.
    always_comb begin
        start_ready = !clash && (mode_eff || !other_live);
        accept      = start_valid && start_ready;
    end

    rtseq_occupancy #(.N_STAGES(NSTG), .WIN(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_func (start_func),
        .load     (accept),
        .clash    (clash),
        .busy_now (busy_now)
    );

    rtseq_tag_pipe #(.WIN(DEPTH)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_func  (start_func),
        .query_func (start_func),
        .live       (live),
        .func       (func),
        .empty      (empty),
        .other_live (other_live),
        .done_valid (done_valid),
        .done_func  (done_func)
    );

    rtseq_route #(.N_STAGES(NSTG), .WIN(DEPTH)) u_route (
        .live      (live),
        .func      (func),
        .stage_en  (stage_en),
        .stage_sel (stage_sel)
    );

    // Enables decoded from tags must agree with the separately kept map (R6).
    assert_map_tracks_tags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en == busy_now);

    // An accepted start opens on stage A from the external operand (R2, R3, R4).
    assert_first_step_on_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready) |=> (stage_en[0] && stage_sel[1:0] == SRC_EXT));

    // A completion follows the final stage of its function: A for code 0, C for code 1 (R5).
    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_func ? $past(stage_en[2]) : $past(stage_en[0])));

    // Static mode never holds both functions in flight at once (R8).
    assert_static_one_func_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_eff |-> !((|(live & func)) && (|(live & ~func))));

    // The latched mode cannot move while work is in flight (R10).
    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |=> $stable(mode_q));
endmodule

// File: tb/rtseq_sequencer_bench.sv
module rtseq_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NV         = 21;

    // Vector: {mode, first func, second func, gap[3:0], expected ready}
    localparam logic [7:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,4'd1,1'b1}, {1'b1,1'b0,1'b0,4'd2,1'b0},
        {1'b1,1'b0,1'b0,4'd3,1'b1}, {1'b1,1'b0,1'b0,4'd4,1'b1},
        {1'b1,1'b0,1'b0,4'd5,1'b0}, {1'b1,1'b1,1'b1,4'd1,1'b1},
        {1'b1,1'b1,1'b1,4'd2,1'b0}, {1'b1,1'b1,1'b1,4'd3,1'b0},
        {1'b1,1'b1,1'b1,4'd4,1'b0}, {1'b1,1'b1,1'b1,4'd5,1'b1},
        {1'b1,1'b0,1'b1,4'd1,1'b0}, {1'b1,1'b0,1'b1,4'd2,1'b0},
        {1'b1,1'b0,1'b1,4'd3,1'b0}, {1'b1,1'b0,1'b1,4'd4,1'b1},
        {1'b1,1'b0,1'b1,4'd5,1'b0}, {1'b1,1'b1,1'b0,4'd1,1'b0},
        {1'b1,1'b1,1'b0,4'd2,1'b1}, {1'b0,1'b0,1'b1,4'd4,1'b0},
        {1'b0,1'b1,1'b0,4'd2,1'b0}, {1'b0,1'b0,1'b0,4'd1,1'b1},
        {1'b0,1'b1,1'b1,4'd5,1'b1}
    };

    localparam int SEQ0 [6] = '{0, 1, 2, 1, 2, 0};
    localparam int SEQ1 [6] = '{0, 2, 1, 0, 1, 2};
    localparam int SRC0 [6] = '{0, 1, 2, 3, 2, 3};
    localparam int SRC1 [6] = '{0, 1, 3, 2, 1, 2};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_dyn = 1'b0;
    logic       start_valid = 1'b0;
    logic       start_func = 1'b0;
    logic       start_ready;
    logic [2:0] stage_en;
    logic [5:0] stage_sel;
    logic       done_valid;
    logic       done_func;

    int checks = 0;
    int errors = 0;

    rtseq_sequencer u_rtseq_sequencer (
        .clk, .rst_n, .mode_dyn, .start_valid, .start_func, .start_ready,
        .stage_en, .stage_sel, .done_valid, .done_func
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present a request at the current negedge; return at the negedge of its first step.
    task automatic issue(input logic f);
        start_valid = 1'b1;
        start_func  = f;
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (10) @(negedge clk);
    endtask

    // Follow one evaluation through its six steps and its completion.
    task automatic trace(input logic f, input string req);
        int st;
        logic [5:0] es;
        issue(f);
        for (int k = 0; k < 6; k++) begin
            #1;
            st = f ? SEQ1[k] : SEQ0[k];
            es = '0;
            es[2*st +: 2] = 2'(f ? SRC1[k] : SRC0[k]);
            check(stage_en == 3'(1 << st), req, "stage_en", int'(stage_en), 1 << st);
            check(stage_sel == es, "R4", "stage_sel", int'(stage_sel), int'(es));
            check(done_valid == 1'b0, "R5", "early done", int'(done_valid), 0);
            @(negedge clk);
        end
        #1;
        check(done_valid && done_func == f, "R5", "done pulse/func",
              int'({done_valid, done_func}), int'({1'b1, f}));
        @(negedge clk);
        #1;
        check(done_valid == 1'b0, "R5", "done single cycle", int'(done_valid), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(stage_en == 3'b000 && stage_sel == 6'd0, "R1", "idle outputs",
              int'({stage_en, stage_sel}), 0);
        check(done_valid == 1'b0, "R1", "done idle", int'(done_valid), 0);
        check(start_ready == 1'b1, "R1", "ready idle", int'(start_ready), 1);
        @(negedge clk);

        trace(1'b0, "R2");
        drain();
        trace(1'b1, "R3");
        drain();

        // Table of spacing vectors: R6, R7, R8, R9.
        for (int v = 0; v < NV; v++) begin
            logic m, f1, f2, e;
            int d;
            string rq;
            {m, f1, f2} = VEC[v][7:5];
            d = int'(VEC[v][4:1]);
            e = VEC[v][0];
            rq = !m ? "R8" : (f1 == f2) ? "R7" : "R9";
            mode_dyn = m;
            @(negedge clk);
            issue(f1);
            repeat (d - 1) @(negedge clk);
            start_func  = f2;
            start_valid = 1'b1;
            #1;
            check(start_ready == e, rq, $sformatf("R6 ready vec %0d", v),
                  int'(start_ready), int'(e));
            start_valid = 1'b0;
            drain();
        end

        // R6: held request in dynamic mode, taken at gap 4, overlap R9.
        mode_dyn = 1'b1;
        @(negedge clk);
        issue(1'b0);
        @(negedge clk);
        start_func = 1'b1;
        start_valid = 1'b1;
        #1; check(start_ready == 1'b0, "R6", "held gap2", int'(start_ready), 0);
        @(negedge clk);
        #1; check(start_ready == 1'b0, "R6", "held gap3", int'(start_ready), 0);
        @(negedge clk);
        #1; check(start_ready == 1'b1, "R6", "held gap4", int'(start_ready), 1);
        @(negedge clk);
        start_valid = 1'b0;
        #1;
        check(stage_en == 3'b101, "R9", "overlap enables", int'(stage_en), 5);
        check(stage_sel == 6'b100000, "R9", "overlap selects", int'(stage_sel), 32);
        repeat (2) @(negedge clk);
        #1;
        check(done_valid && !done_func, "R5", "first done", int'({done_valid, done_func}), 2);
        repeat (4) @(negedge clk);
        #1;
        check(done_valid && done_func, "R5", "second done", int'({done_valid, done_func}), 3);
        drain();

        // R8: static mode waits for full drain before switching function.
        mode_dyn = 1'b0;
        @(negedge clk);
        issue(1'b0);
        start_func = 1'b1;
        start_valid = 1'b1;
        repeat (5) @(negedge clk);
        #1; check(start_ready == 1'b0, "R8", "last step busy", int'(start_ready), 0);
        @(negedge clk);
        #1; check(start_ready == 1'b1, "R8", "after drain", int'(start_ready), 1);
        start_valid = 1'b0;
        drain();

        // R10: mode change while busy is ignored; takes effect after drain.
        mode_dyn = 1'b0;
        @(negedge clk);
        issue(1'b0);
        mode_dyn = 1'b1;
        repeat (3) @(negedge clk);
        start_func = 1'b1;
        start_valid = 1'b1;
        #1; check(start_ready == 1'b0, "R10", "mode frozen", int'(start_ready), 0);
        start_valid = 1'b0;
        drain();
        issue(1'b0);
        repeat (3) @(negedge clk);
        start_func = 1'b1;
        start_valid = 1'b1;
        #1; check(start_ready == 1'b1, "R10", "mode applied", int'(start_ready), 1);
        start_valid = 1'b0;
        drain();

        // R1: reset in flight clears everything.
        issue(1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(stage_en == 3'b000 && stage_sel == 6'd0, "R1", "flight reset outputs",
              int'({stage_en, stage_sel}), 0);
        check(start_ready == 1'b1, "R1", "flight reset ready", int'(start_ready), 1);
        repeat (6) @(negedge clk);
        #1;
        check(done_valid == 1'b0, "R1", "no done after reset", int'(done_valid), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule